// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block runs external data memory read and write cycles over a narrow pin bus, in the way classic 8-bit microcontrollers do it. The lower half of the address and the data byte share one 8-bit port. The upper half of the address has a port of its own. An address latch enable tells an external latch when to capture the low address. Active-low read and write strobes frame the data transfer.

A core-side requester raises a read or write request for one clock, with a 16-bit address and, for writes, a data byte. The block answers with a one-clock done pulse. On a read, the captured byte is held on the read data output.

The block runs on the oscillator clock. All phase timing is counted in CPU clocks, built from an internal enable. A clock-mode input selects two oscillator clocks per CPU clock or one. A stretch input widens the strobe phase for slow devices. Both mode inputs are sampled when a request is accepted. The low port is brought out as separate output, enable and input signals, so that the pad ring can build the tri-state driver.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held and after it is released with no request, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0 and `done`=0.
- R2: A request (`req_rd` or `req_wr` high at a clock edge) is accepted only when the controller is idle. Requests raised during a cycle start no further cycle, so exactly one bus cycle occurs per accepted request.
- R3: A cycle begins with `ale`=1 for exactly one CPU clock, with `ad_oe`=1 and `ad_out` equal to address bits 7:0. `addr_hi` equals address bits 15:8 from the first clock of the cycle through the done pulse. Neither strobe is low while `ale`=1.
- R4: A request with `req_rd`=1 is a read, even if `req_wr` is also high. In a read only `rd_n` pulses low, and `ad_oe` is 0 from the end of the ALE phase until the cycle ends, so the port is floated before `rd_n` falls.
- R5: In a read, `rdata` takes the value on `ad_in` at the oscillator edge that ends the last CPU clock of the `rd_n` pulse. That value is held on `rdata` when `done` pulses and afterwards.
- R6: In a write only `wr_n` pulses low. From the end of the ALE phase, through the whole `wr_n` pulse, until one CPU clock after `wr_n` rises, `ad_oe`=1 and `ad_out` carries the write data.
- R7: The strobe is low for 3 CPU clocks when `stretch`=0 and for 15 CPU clocks when `stretch`=1.
- R8: A cycle lasts 6 CPU clocks when unstretched and 18 when stretched, counted from the clock edge where `ale` rises to the edge where `done` rises. `done` is high for exactly one oscillator clock.
- R9: One CPU clock is 2 oscillator clocks when `x2_mode`=0 and 1 oscillator clock when `x2_mode`=1.
- R10: `stretch` and `x2_mode` are sampled at acceptance. Changing them during a cycle does not alter that cycle's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x2_mode | input | 1 | 1: one oscillator clock per CPU clock; 0: two |
| stretch | input | 1 | 1: 15-CPU-clock strobe; 0: 3-CPU-clock strobe |
| req_rd | input | 1 | Read request, sampled while idle |
| req_wr | input | 1 | Write request, sampled while idle |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| rdata | output | 8 | Last captured read byte |
| done | output | 1 | One-clock pulse at the end of a cycle |
| addr_hi | output | 8 | Upper address port |
| ad_out | output | 8 | Low port output value (address, then write data) |
| ad_in | input | 8 | Low port input value from the pad |
| ad_oe | output | 1 | Low port drive enable |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
Reads and writes are each run in all four combinations of clock mode and stretch. Comparing the measured ALE width, strobe width and total length separates a wrong CPU-clock divisor from a wrong strobe count or a wrong fixed-phase count. Reads take data from a memory model that depends on the latched address, so a wrong capture edge or a wrong latched address shows up as a data mismatch. Extra requests and mode flips placed in the middle of a cycle, a request with both strobes raised, and the all-ones and all-zeros addresses test acceptance, direction priority and the mode freeze.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ALE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_t;

  // Number of CPU clocks outside the strobe phase (ALE, setup, hold).
  localparam int FIXED_CPU = 3;

  // Oscillator clocks per CPU clock for the chosen clock mode.
  function automatic int osc_per_cpu(logic x2, int std_div, int x2_div);
    return x2 ? x2_div : std_div;
  endfunction

  // Strobe phase length in CPU clocks.
  function automatic int strobe_cpu(logic slow, int norm, int lng);
    return slow ? lng : norm;
  endfunction

  // Whole cycle length in CPU clocks.
  function automatic int cycle_cpu(logic slow, int norm, int lng);
    return strobe_cpu(slow, norm, lng) + FIXED_CPU;
  endfunction

endpackage

// File: rtl/xbus_clkdiv.sv
module xbus_clkdiv import xbus_pkg::*; #(
  parameter int DIV_STD = 2,
  parameter int DIV_X2  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic x2_q,
  output logic tick
);
  localparam int DIVW = (DIV_STD > 1) ? $clog2(DIV_STD) : 1;

  logic [DIVW-1:0] div_cnt;
  logic [DIVW-1:0] lim;

  assign lim  = DIVW'(osc_per_cpu(x2_q, DIV_STD, DIV_X2) - 1);
  assign tick = busy && (div_cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_cnt <= '0;
    else if (!busy)  div_cnt <= '0;
    else if (tick)   div_cnt <= '0;
    else             div_cnt <= div_cnt + 1'b1;
  end

  // R9: in standard mode two CPU-clock ticks are never adjacent
  p_tick_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (DIV_STD > 1 && tick && !x2_q) |-> !$past(tick));

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq import xbus_pkg::*; #(
  parameter int STRB_NORM = 3,
  parameter int STRB_LONG = 15
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req_rd,
  input  logic   req_wr,
  input  logic   stretch,
  input  logic   x2_mode,
  input  logic   tick,
  output phase_t phase,
  output phase_t phase_nxt,
  output logic   accept,
  output logic   busy,
  output logic   is_rd,
  output logic   stretch_q,
  output logic   x2_q,
  output logic   last_strobe,
  output logic   finish
);
  localparam int CNT_W = $clog2(STRB_LONG + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] strb_len;

  assign strb_len    = CNT_W'(strobe_cpu(stretch_q, STRB_NORM, STRB_LONG));
  assign busy        = (phase != PH_IDLE);
  assign accept      = (phase == PH_IDLE) && (req_rd || req_wr);
  assign last_strobe = tick && (phase == PH_STROBE) && (cnt == strb_len - 1'b1);
  assign finish      = tick && (phase == PH_HOLD);

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_IDLE:   if (req_rd || req_wr) phase_nxt = PH_ALE;
      PH_ALE:    if (tick)             phase_nxt = PH_SETUP;
      PH_SETUP:  if (tick)             phase_nxt = PH_STROBE;
      PH_STROBE: if (last_strobe)      phase_nxt = PH_HOLD;
      PH_HOLD:   if (tick)             phase_nxt = PH_IDLE;
      default:                         phase_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      is_rd     <= 1'b0;
      stretch_q <= 1'b0;
      x2_q      <= 1'b0;
      cnt       <= '0;
    end else begin
      phase <= phase_nxt;
      if (accept) begin
        is_rd     <= req_rd;
        stretch_q <= stretch;
        x2_q      <= x2_mode;
      end
      if (phase != PH_STROBE) cnt <= '0;
      else if (tick)          cnt <= cnt + 1'b1;
    end
  end

  // R2: the ALE phase is only ever entered from idle
  p_start_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ALE && $past(phase) != PH_ALE) |-> ($past(phase) == PH_IDLE));

  // R7: the strobe counter stays inside the configured width
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_STROBE) |-> (cnt < strb_len));

  // R10: captured modes do not move during a cycle
  p_mode_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(stretch_q) && $stable(x2_q)));

endmodule

// File: rtl/xbus_pins.sv
module xbus_pins import xbus_pkg::*; #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_t            phase,
  input  phase_t            phase_nxt,
  input  logic              accept,
  input  logic              is_rd,
  input  logic              last_strobe,
  input  logic              finish,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n
);
  logic [DATA_W-1:0] wdata_q;
  logic              nxt_ale;
  logic              nxt_strobe;
  logic              nxt_data_ph;

  assign nxt_ale     = (phase_nxt == PH_ALE);
  assign nxt_strobe  = (phase_nxt == PH_STROBE);
  assign nxt_data_ph = (phase_nxt == PH_SETUP) || (phase_nxt == PH_STROBE) ||
                       (phase_nxt == PH_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale     <= 1'b0;
      rd_n    <= 1'b1;
      wr_n    <= 1'b1;
      ad_oe   <= 1'b0;
      ad_out  <= '0;
      addr_hi <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      done    <= 1'b0;
    end else begin
      ale   <= nxt_ale;
      rd_n  <= !(nxt_strobe && is_rd);
      wr_n  <= !(nxt_strobe && !is_rd);
      ad_oe <= nxt_ale || (nxt_data_ph && !is_rd);
      if (accept) begin
        addr_hi <= req_addr[ADDR_W-1:DATA_W];
        ad_out  <= req_addr[DATA_W-1:0];
        wdata_q <= req_wdata;
      end else if (phase == PH_ALE && phase_nxt == PH_SETUP) begin
        ad_out <= wdata_q;
      end
      if (last_strobe && is_rd) rdata <= ad_in;
      done <= finish;
    end
  end

  // R4: read and write strobes are never low together
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R4: low port is floated whenever the read strobe is low
  p_read_float_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

  // R6: low port is driven whenever the write strobe is low
  p_write_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> ad_oe);

  // R6: data still driven in the clock after the write strobe rises
  p_wr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> ad_oe);

  // R3: no strobe while the address latch enable is high
  p_ale_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (rd_n && wr_n && ad_oe));

  // R8: done is a single-clock pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl import xbus_pkg::*; #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int STRB_NORM = 3,
  parameter int STRB_LONG = 15,
  parameter int DIV_STD   = 2,
  parameter int DIV_X2    = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     x2_mode,
  input  logic                     stretch,
  input  logic                     req_rd,
  input  logic                     req_wr,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic [DATA_W-1:0]        rdata,
  output logic                     done,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic [DATA_W-1:0]        ad_out,
  input  logic [DATA_W-1:0]        ad_in,
  output logic                     ad_oe,
  output logic                     ale,
  output logic                     rd_n,
  output logic                     wr_n
);
  localparam int SW_W = $clog2(STRB_LONG * DIV_STD + 1);
  localparam int CY_W = $clog2((STRB_LONG + FIXED_CPU) * DIV_STD + 1);

  phase_t phase, phase_nxt;
  logic   accept, busy, is_rd, stretch_q, x2_q, tick, last_strobe, finish;

  xbus_clkdiv #(.DIV_STD(DIV_STD), .DIV_X2(DIV_X2)) u_div (
    .clk(clk), .rst_n(rst_n), .busy(busy), .x2_q(x2_q), .tick(tick)
  );

  xbus_seq #(.STRB_NORM(STRB_NORM), .STRB_LONG(STRB_LONG)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_rd(req_rd), .req_wr(req_wr),
    .stretch(stretch), .x2_mode(x2_mode), .tick(tick),
    .phase(phase), .phase_nxt(phase_nxt), .accept(accept), .busy(busy),
    .is_rd(is_rd), .stretch_q(stretch_q), .x2_q(x2_q),
    .last_strobe(last_strobe), .finish(finish)
  );

  xbus_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk(clk), .rst_n(rst_n), .phase(phase), .phase_nxt(phase_nxt),
    .accept(accept), .is_rd(is_rd), .last_strobe(last_strobe),
    .finish(finish), .req_addr(req_addr), .req_wdata(req_wdata),
    .ad_in(ad_in), .rdata(rdata), .done(done), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
  );

  // Observation counters for the timing properties below.
  logic [SW_W-1:0] strb_cnt;
  logic [CY_W-1:0] cyc_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strb_cnt <= '0;
      cyc_cnt  <= '0;
    end else begin
      strb_cnt <= (!rd_n || !wr_n) ? strb_cnt + 1'b1 : '0;
      cyc_cnt  <= busy ? cyc_cnt + 1'b1 : '0;
    end
  end

  // R7: strobe pulse width in oscillator clocks
  p_strobe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n && wr_n) |->
      (strb_cnt == SW_W'(osc_per_cpu(x2_q, DIV_STD, DIV_X2) *
                         strobe_cpu(stretch_q, STRB_NORM, STRB_LONG))));

  // R8: whole cycle length in oscillator clocks
  p_cycle_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cyc_cnt == CY_W'(osc_per_cpu(x2_q, DIV_STD, DIV_X2) *
                               cycle_cpu(stretch_q, STRB_NORM, STRB_LONG))));

  // R3: upper address port steady through a cycle
  p_addr_hi_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_hi));

endmodule

// File: tb/xbus_ctrl_test.sv
module xbus_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       x2_mode = 1'b0, stretch = 1'b0, req_rd = 1'b0, req_wr = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rdata, addr_hi, ad_out, ad_in;
  logic        done, ad_oe, ale, rd_n, wr_n;
  logic [7:0]  lat_lo = '0;

  int n_checks = 0, n_errors = 0, n_exp = 0, n_seen = 0;
  bit ended = 0;

  typedef struct {
    bit          rd;
    logic [15:0] addr;
    logic [7:0]  data;
    int          d;
    int          w;
  } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem_model(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h96;
  endfunction

  assign ad_in = !rd_n ? mem_model({addr_hi, lat_lo}) : 8'hEE;

  xbus_ctrl uut (
    .clk(clk), .rst_n(rst_n), .x2_mode(x2_mode), .stretch(stretch),
    .req_rd(req_rd), .req_wr(req_wr), .req_addr(req_addr),
    .req_wdata(req_wdata), .rdata(rdata), .done(done), .addr_hi(addr_hi),
    .ad_out(ad_out), .ad_in(ad_in), .ad_oe(ad_oe), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  // Transparent external latch model: follows the port while ALE is high.
  always @(negedge clk) if (ale) lat_lo <= ad_out;

  // Monitor: pops expected items and measures each bus cycle.
  item_t cur;
  bit    active = 0, ale_q = 0, wr_q = 1, done_q = 0;
  bit    bad_hi, bad_dir, bad_wd;
  int    t, ale_w, str_w;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ale && !ale_q) begin
        if (sb.size() == 0) begin
          chk(0, "R2", "cycle started with no accepted request", 1, 0);
        end else begin
          cur = sb.pop_front();
          active = 1; n_seen++;
          t = 0; ale_w = 0; str_w = 0;
          bad_hi = 0; bad_dir = 0; bad_wd = 0;
          chk(ad_oe && ad_out == cur.addr[7:0], "R3", "low address on port during ALE",
              int'(ad_out), int'(cur.addr[7:0]));
        end
      end else if (active) begin
        t++;
      end
      if (active) begin
        if (ale) ale_w++;
        if (!rd_n || !wr_n) str_w++;
        if (addr_hi != cur.addr[15:8]) bad_hi = 1;
        if (cur.rd) begin
          if (!wr_n || (!ale && ad_oe)) bad_dir = 1;
        end else begin
          if (!rd_n) bad_dir = 1;
          if (!ale && !done && (!ad_oe || ad_out != cur.data)) bad_wd = 1;
          if (wr_n && !wr_q)
            chk(ad_oe && ad_out == cur.data, "R6", "write data held after strobe rises",
                int'(ad_out), int'(cur.data));
        end
        if (done) begin
          chk(ale_w == cur.d, "R9", "ALE width in oscillator clocks", ale_w, cur.d);
          chk(str_w == cur.w * cur.d, "R7", "strobe width in oscillator clocks",
              str_w, cur.w * cur.d);
          chk(t == (cur.w + 3) * cur.d, "R8", "cycle length in oscillator clocks",
              t, (cur.w + 3) * cur.d);
          chk(!bad_hi, "R3", "upper address held through cycle",
              int'(addr_hi), int'(cur.addr[15:8]));
          chk(lat_lo == cur.addr[7:0], "R3", "latched low address",
              int'(lat_lo), int'(cur.addr[7:0]));
          if (cur.rd) begin
            chk(!bad_dir, "R4", "read: only rd_n low and port floated", 1, 0);
            chk(rdata == cur.data, "R5", "read data", int'(rdata), int'(cur.data));
          end else begin
            chk(!bad_dir, "R6", "write: only wr_n low", 1, 0);
            chk(!bad_wd, "R6", "write data driven from setup to hold", 1, 0);
          end
          active = 0;
        end
      end else if (done && !(ale && !ale_q)) begin
        chk(0, "R8", "done without a cycle", 1, 0);
      end
      if (done && done_q) chk(0, "R8", "done longer than one clock", 2, 1);
    end
    ale_q = ale; wr_q = wr_n; done_q = done;
  end

  // Driver: pushes the expected item and runs one request.
  task automatic xfer(bit rd, bit wr, logic [15:0] a, logic [7:0] wd,
                      bit x2, bit st, bit poke);
    item_t it;
    @(negedge clk);
    x2_mode = x2; stretch = st; req_addr = a; req_wdata = wd;
    req_rd = rd; req_wr = wr;
    it.rd = rd; it.addr = a; it.data = rd ? mem_model(a) : wd;
    it.d = x2 ? 1 : 2; it.w = st ? 15 : 3;
    sb.push_back(it); n_exp++;
    @(negedge clk);
    req_rd = 0; req_wr = 0;
    if (poke) begin
      // R2 / R10: request and mode flip while busy
      repeat (3) @(negedge clk);
      req_wr = 1; req_addr = ~a; req_wdata = ~wd;
      stretch = !st; x2_mode = !x2;
      @(negedge clk);
      req_wr = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    chk(0, "WDOG", "run did not complete", 0, 1);
    finish_sim();
  end

  initial begin : stimulus
    repeat (3) @(negedge clk);
    // R1: levels during reset
    chk(!ale && rd_n && wr_n && !ad_oe && !done, "R1", "pin levels in reset",
        {ale, rd_n, wr_n, ad_oe, done}, 5'b01100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!ale && rd_n && wr_n && !ad_oe && !done, "R1", "idle pin levels after reset",
        {ale, rd_n, wr_n, ad_oe, done}, 5'b01100);

    xfer(1, 0, 16'h1234, 8'h00, 0, 0, 0);   // R4 R5 R9 standard read
    xfer(0, 1, 16'hA5C3, 8'h3C, 0, 0, 0);   // R6 standard write
    xfer(1, 0, 16'h0F0F, 8'h00, 1, 0, 0);   // R9 x2 read
    xfer(0, 1, 16'h7E81, 8'hC5, 1, 0, 0);   // R9 x2 write
    xfer(1, 0, 16'hBEEF, 8'h00, 0, 1, 0);   // R7 stretched read
    xfer(0, 1, 16'h4321, 8'h5A, 0, 1, 0);   // R7 stretched write
    xfer(1, 0, 16'h8001, 8'h00, 1, 1, 0);   // R7 R9 x2 stretched read
    xfer(0, 1, 16'h00FF, 8'hA0, 1, 1, 0);   // R7 R9 x2 stretched write
    xfer(1, 0, 16'h2468, 8'h00, 1, 0, 1);   // R2 R10 poke during fast read
    xfer(0, 1, 16'h1357, 8'h99, 0, 1, 1);   // R2 R10 poke during slow write
    xfer(1, 1, 16'h6C6C, 8'h11, 0, 0, 0);   // R4 both raised: read wins
    xfer(1, 0, 16'hFFFF, 8'h00, 0, 0, 0);   // R3 all-ones address
    xfer(0, 1, 16'h0000, 8'hFF, 1, 0, 0);   // R3 all-zeros address

    repeat (40) @(negedge clk);
    chk(sb.size() == 0, "R2", "every accepted request produced a cycle", sb.size(), 0);
    chk(n_seen == n_exp, "R2", "number of bus cycles", n_seen, n_exp);
    chk(!ale && rd_n && wr_n && !ad_oe, "R1", "idle levels between cycles",
        {ale, rd_n, wr_n, ad_oe}, 4'b0110);
    finish_sim();
  end

endmodule